// File: doc/BRIEF.md
# PCIe Root-Port Link Speed Sequencer

This block walks a PCIe root-port controller through link bring-up in two stages. It first limits the advertised maximum link speed to Gen1 and turns on the link training state machine. Once the link reports that it is up, the block raises the speed limit to Gen2 and asks the controller for a directed speed change. It then waits for the controller to clear its speed-change request bit and checks the link again. Starting at Gen1 keeps devices behind PCIe switches from being missed during the first training pass.

Every register update is a read-modify-write on a simple register port. The port has a one-cycle read latency and no handshake. Every wait is a bounded poll. The bound on the number of attempts and the spacing between attempts are both parameters. At the end the block pulses `done`. On failure it raises `fail`. On success it reports the negotiated generation on `cur_gen`. Both values hold until the next start.

Top module: `link_speed_seq`

## Requirements
- R1: After an accepted start, the block reads offset 0x7C and writes it back with bits [3:0] = 1 (Gen1) and bits [31:4] equal to the value read. `ltssm_en` rises in the cycle right after that write.
- R2: `ltssm_en` is 0 after reset and is cleared by an accepted start. Once set, it stays 1 until the next accepted start, on both success and failure.
- R3: The link counts as up only when `link_up`=1 and `link_training`=0. A link wait checks the link at most POLL_LIMIT times, one check every POLL_GAP+1 cycles. If no check sees the link up, the bring-up fails.
- R4: After the first link-up, offset 0x7C is rewritten with bits [3:0] = 2 (Gen2) and all other bits kept. Offset 0x80C is then read and written back with bit 17 set and all other bits kept.
- R5: Bit 17 of offset 0x80C is polled by reads of that offset, with at most POLL_LIMIT reads. The first read that returns it clear starts a second link wait. If all POLL_LIMIT reads return it set, the bring-up fails.
- R6: When the second link wait succeeds, offset 0x80 is read. `cur_gen` takes bits [19:16] of the value read, `done` is high for exactly one cycle, and `fail` is 0.
- R7: On failure, `done` is high for one cycle with `fail`=1 and `cur_gen`=0. `fail` and `cur_gen` keep their values until the next accepted start.
- R8: Read data is taken from `reg_rdata` one cycle after the read request. `reg_req` is 0 while the block is idle, and `reg_we` is high only together with `reg_req`.
- R9: A `start` pulse that arrives while a bring-up is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up (accepted only when idle) |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 12 | Register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid one cycle after a read request |
| ltssm_en | output | 1 | Enable for link training |
| link_up | input | 1 | Physical layer reports link up |
| link_training | input | 1 | Link training still in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Bring-up failed; held until next start |
| cur_gen | output | 4 | Negotiated generation; held until next start |

## Verification
Some properties are checked by assertions on every cycle. The training enable may rise only right after a Gen1 write to the capability offset. Any later write to that offset must carry Gen2, and every write to the speed-control offset must set the request bit. `done` must be a single-cycle pulse, and `fail` and `cur_gen` must not change between completions. The poll counter must never miss past its last attempt. Other behaviour only the bench scenarios can show: that bits outside the speed field survive each read-modify-write, that a link wait gives up after exactly the bounded number of checks, that a speed-change bit which clears on poll 200 still succeeds while one that never clears fails, and that a start arriving mid-run is ignored.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int GEN_W  = 4;

    // register offsets used by the sequence
    localparam logic [ADDR_W-1:0] OFS_LCAP = 12'h07C;
    localparam logic [ADDR_W-1:0] OFS_SCTL = 12'h80C;
    localparam logic [ADDR_W-1:0] OFS_LSTS = 12'h080;

    // field positions
    localparam int SPD_LSB = 0;
    localparam int SC_BIT  = 17;
    localparam int NEG_LSB = 16;

    localparam logic [GEN_W-1:0] SPD_G1 = 4'd1;
    localparam logic [GEN_W-1:0] SPD_G2 = 4'd2;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_G1_RD, ST_G1_CAP, ST_G1_WR,
        ST_LK1_CHK, ST_LK1_GAP,
        ST_G2_RD, ST_G2_CAP, ST_G2_WR,
        ST_SC_RD, ST_SC_CAP, ST_SC_WR,
        ST_SP_RD, ST_SP_CHK, ST_SP_GAP,
        ST_LK2_CHK, ST_LK2_GAP,
        ST_GEN_RD, ST_GEN_CAP
    } seq_state_t;

    typedef enum logic [1:0] {
        MG_KEEP,
        MG_SPD_G1,
        MG_SPD_G2,
        MG_SET_SC
    } merge_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        merge_t            mg;
    } bus_op_t;

    // Apply one field update to a previously read word
    function automatic logic [DATA_W-1:0] merge_word(
        input logic [DATA_W-1:0] old_w,
        input merge_t            mg
    );
        logic [DATA_W-1:0] w;
        w = old_w;
        case (mg)
            MG_SPD_G1: w[SPD_LSB +: GEN_W] = SPD_G1;
            MG_SPD_G2: w[SPD_LSB +: GEN_W] = SPD_G2;
            MG_SET_SC: w[SC_BIT] = 1'b1;
            default:   w = old_w;
        endcase
        return w;
    endfunction

    // States in which the attempt counter must keep its value
    function automatic logic is_poll_state(input seq_state_t s);
        return (s == ST_LK1_CHK) || (s == ST_LK1_GAP) ||
               (s == ST_SP_RD)   || (s == ST_SP_CHK)  || (s == ST_SP_GAP) ||
               (s == ST_LK2_CHK) || (s == ST_LK2_GAP);
    endfunction

    function automatic logic is_cap_state(input seq_state_t s);
        return (s == ST_G1_CAP) || (s == ST_G2_CAP) || (s == ST_SC_CAP);
    endfunction

endpackage

// File: rtl/lsq_opdec.sv
module lsq_opdec
    import lsq_pkg::*;
(
    input  seq_state_t st,
    output bus_op_t    op
);

    always_comb begin
        op = '{req: 1'b0, we: 1'b0, addr: '0, mg: MG_KEEP};
        case (st)
            ST_G1_RD:  op = '{req: 1'b1, we: 1'b0, addr: OFS_LCAP, mg: MG_KEEP};
            ST_G1_WR:  op = '{req: 1'b1, we: 1'b1, addr: OFS_LCAP, mg: MG_SPD_G1};
            ST_G2_RD:  op = '{req: 1'b1, we: 1'b0, addr: OFS_LCAP, mg: MG_KEEP};
            ST_G2_WR:  op = '{req: 1'b1, we: 1'b1, addr: OFS_LCAP, mg: MG_SPD_G2};
            ST_SC_RD:  op = '{req: 1'b1, we: 1'b0, addr: OFS_SCTL, mg: MG_KEEP};
            ST_SC_WR:  op = '{req: 1'b1, we: 1'b1, addr: OFS_SCTL, mg: MG_SET_SC};
            ST_SP_RD:  op = '{req: 1'b1, we: 1'b0, addr: OFS_SCTL, mg: MG_KEEP};
            ST_GEN_RD: op = '{req: 1'b1, we: 1'b0, addr: OFS_LSTS, mg: MG_KEEP};
            default:   op = '{req: 1'b0, we: 1'b0, addr: '0, mg: MG_KEEP};
        endcase
    end

endmodule

// File: rtl/lsq_rmw.sv
module lsq_rmw
    import lsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] rdata,
    input  merge_t            mg,
    output logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (cap_en) begin
            held_q <= rdata;
        end
    end

    assign wdata = merge_word(held_q, mg);

endmodule

// File: rtl/lsq_pacer.sv
module lsq_pacer #(
    parameter int POLL_LIMIT = 200,
    parameter int POLL_GAP   = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last,
    output logic waiting
);

    localparam int CNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
    localparam int TMR_W = $clog2(POLL_GAP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            tmr_q <= '0;
        end else if (miss) begin
            cnt_q <= cnt_q + 1'b1;
            tmr_q <= TMR_W'(POLL_GAP - 1);
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign last    = (cnt_q == CNT_W'(POLL_LIMIT - 1));
    assign waiting = (tmr_q != '0);

    AST_NO_MISS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        miss |-> !last);  // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        last |=> (last || (cnt_q == '0)));  // R3

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
    import lsq_pkg::*;
#(
    parameter int POLL_LIMIT = 200,
    parameter int POLL_GAP   = 25000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ltssm_en,
    input  logic              link_up,
    input  logic              link_training,
    output logic              done,
    output logic              fail,
    output logic [GEN_W-1:0]  cur_gen
);

    seq_state_t st_q, st_nx;
    bus_op_t    op;
    logic       pc_clr, pc_miss, pc_last, pc_wait;
    logic       fin_ok, fin_bad;
    logic       link_ok, sc_pending;

    assign link_ok    = link_up && !link_training;
    assign sc_pending = reg_rdata[SC_BIT];

    lsq_opdec u_opdec (
        .st (st_q),
        .op (op)
    );

    lsq_rmw u_rmw (
        .clk    (clk),
        .rst    (rst),
        .cap_en (is_cap_state(st_q)),
        .rdata  (reg_rdata),
        .mg     (op.mg),
        .wdata  (reg_wdata)
    );

    lsq_pacer #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .clr     (pc_clr),
        .miss    (pc_miss),
        .last    (pc_last),
        .waiting (pc_wait)
    );

    assign reg_req  = op.req;
    assign reg_we   = op.we;
    assign reg_addr = op.addr;

    always_comb begin
        st_nx   = st_q;
        pc_miss = 1'b0;
        fin_ok  = 1'b0;
        fin_bad = 1'b0;
        pc_clr  = !is_poll_state(st_q);
        case (st_q)
            ST_IDLE:    if (start) st_nx = ST_G1_RD;
            ST_G1_RD:   st_nx = ST_G1_CAP;
            ST_G1_CAP:  st_nx = ST_G1_WR;
            ST_G1_WR:   st_nx = ST_LK1_CHK;
            ST_LK1_CHK: begin
                if (link_ok) begin
                    st_nx = ST_G2_RD;
                end else if (pc_last) begin
                    fin_bad = 1'b1;
                    st_nx   = ST_IDLE;
                end else begin
                    pc_miss = 1'b1;
                    st_nx   = ST_LK1_GAP;
                end
            end
            ST_LK1_GAP: if (!pc_wait) st_nx = ST_LK1_CHK;
            ST_G2_RD:   st_nx = ST_G2_CAP;
            ST_G2_CAP:  st_nx = ST_G2_WR;
            ST_G2_WR:   st_nx = ST_SC_RD;
            ST_SC_RD:   st_nx = ST_SC_CAP;
            ST_SC_CAP:  st_nx = ST_SC_WR;
            ST_SC_WR:   st_nx = ST_SP_RD;
            ST_SP_RD:   st_nx = ST_SP_CHK;
            ST_SP_CHK: begin
                if (!sc_pending) begin
                    pc_clr = 1'b1;
                    st_nx  = ST_LK2_CHK;
                end else if (pc_last) begin
                    fin_bad = 1'b1;
                    st_nx   = ST_IDLE;
                end else begin
                    pc_miss = 1'b1;
                    st_nx   = ST_SP_GAP;
                end
            end
            ST_SP_GAP:  if (!pc_wait) st_nx = ST_SP_RD;
            ST_LK2_CHK: begin
                if (link_ok) begin
                    st_nx = ST_GEN_RD;
                end else if (pc_last) begin
                    fin_bad = 1'b1;
                    st_nx   = ST_IDLE;
                end else begin
                    pc_miss = 1'b1;
                    st_nx   = ST_LK2_GAP;
                end
            end
            ST_LK2_GAP: if (!pc_wait) st_nx = ST_LK2_CHK;
            ST_GEN_RD:  st_nx = ST_GEN_CAP;
            ST_GEN_CAP: begin
                fin_ok = 1'b1;
                st_nx  = ST_IDLE;
            end
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ltssm_en <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            cur_gen  <= '0;
        end else begin
            st_q <= st_nx;
            done <= fin_ok || fin_bad;
            if (st_q == ST_IDLE && start) begin
                ltssm_en <= 1'b0;
                fail     <= 1'b0;
                cur_gen  <= '0;
            end
            if (st_q == ST_G1_WR) begin
                ltssm_en <= 1'b1;
            end
            if (fin_bad) begin
                fail <= 1'b1;
            end
            if (fin_ok) begin
                cur_gen <= reg_rdata[NEG_LSB +: GEN_W];
            end
        end
    end

    AST_EN_AFTER_G1: assert property (@(posedge clk) disable iff (rst)
        $rose(ltssm_en) |-> $past(reg_req && reg_we && reg_addr == OFS_LCAP &&
                                  reg_wdata[SPD_LSB +: GEN_W] == SPD_G1));  // R1

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ltssm_en && !start) |=> ltssm_en);  // R2

    AST_G2_WHEN_TRAINED: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_addr == OFS_LCAP && ltssm_en)
            |-> (reg_wdata[SPD_LSB +: GEN_W] == SPD_G2));  // R4

    AST_SC_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_addr == OFS_SCTL) |-> reg_wdata[SC_BIT]);  // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R6

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);  // R7

    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_gen) |-> (done || $past(start)));  // R7

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !reg_req);  // R8

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> reg_req);  // R8

endmodule

// File: tb/link_speed_seq_tb.sv
`timescale 1ns/1ps
module link_speed_seq_tb;

    localparam int LIM = 200;
    localparam int GAP = 3;
    localparam int WIN = 199 * (GAP + 1) + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        reg_req, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        ltssm_en;
    logic        link_up = 1'b0;
    logic        link_training = 1'b0;
    logic        done, fail;
    logic [3:0]  cur_gen;

    int errors = 0;
    int checks = 0;

    // environment configuration
    logic [31:0] cfg_7c, cfg_80c, cfg_80;
    int          cfg_k = 1;
    int          cfg_dly = 0;
    bit          cfg_train = 0;
    bit          cfg_drop = 0;
    bit          mdl_clr = 0;

    // register model state
    logic [31:0] r7c = '0, r80c = '0, r80 = '0;
    logic [31:0] sc_wdata = '0;
    bit          sc_seen = 0;
    int          sp_reads = 0, sp_polls = 0, n7c_rd = 0;

    // link model state
    int          en_cnt = 0;
    bit          en_q = 0;
    logic [31:0] r7c_at_en = '0;

    always #2 clk = ~clk;

    link_speed_seq #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .reg_req       (reg_req),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ltssm_en      (ltssm_en),
        .link_up       (link_up),
        .link_training (link_training),
        .done          (done),
        .fail          (fail),
        .cur_gen       (cur_gen)
    );

    // register file with one-cycle read latency; bit 17 of 0x80C clears
    // after cfg_k reads that returned it set
    always @(posedge clk) begin
        if (mdl_clr) begin
            r7c <= cfg_7c; r80c <= cfg_80c; r80 <= cfg_80;
            sc_seen <= 0; sc_wdata <= '0;
            sp_reads <= 0; sp_polls <= 0; n7c_rd <= 0;
        end else if (reg_req) begin
            if (reg_we) begin
                case (reg_addr)
                    12'h07C: r7c <= reg_wdata;
                    12'h080: r80 <= reg_wdata;
                    12'h80C: begin
                        r80c <= reg_wdata;
                        if (reg_wdata[17]) begin
                            sc_seen  <= 1;
                            sc_wdata <= reg_wdata;
                        end
                    end
                    default: ;
                endcase
            end else begin
                case (reg_addr)
                    12'h07C: begin reg_rdata <= r7c; n7c_rd <= n7c_rd + 1; end
                    12'h080: reg_rdata <= r80;
                    12'h80C: begin
                        reg_rdata <= r80c;
                        if (sc_seen) sp_polls <= sp_polls + 1;
                        if (r80c[17]) begin
                            sp_reads <= sp_reads + 1;
                            if (sp_reads + 1 >= cfg_k) r80c[17] <= 1'b0;
                        end
                    end
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    // link model, updated away from the active edge
    always @(negedge clk) begin
        if (!ltssm_en) en_cnt = 0;
        else en_cnt = en_cnt + 1;
        if (ltssm_en && !en_q) r7c_at_en = r7c;
        en_q = ltssm_en;
        link_up = ltssm_en && (cfg_dly >= 0) && (en_cnt >= cfg_dly) &&
                  !(cfg_drop && sc_seen);
        link_training = cfg_train;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] i7c, input logic [31:0] i80c,
                            input logic [3:0] g, input int k, input int dly,
                            input bit trn, input bit drp, input bit poke,
                            input bit exp_fail, input int exp_polls,
                            input bit chk_win);
        int  cyc;
        bit  got;
        bit  f_at;
        logic [3:0] g_at;
        int  en_at;
        cfg_7c  = i7c;
        cfg_80c = i80c;
        cfg_80  = (32'hC3A0_5E71 & ~32'h000F_0000) | (32'(g) << 16);
        cfg_k = k; cfg_dly = dly; cfg_train = trn; cfg_drop = drp;
        mdl_clr = 1;
        @(negedge clk);
        mdl_clr = 0;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 0; got = 0;
        while (!got && cyc < 6000) begin
            start = poke && (cyc == 10 || cyc == 400);
            @(negedge clk);
            cyc++;
            if (done) got = 1;
        end
        start = 0;
        chk(got, "R6", "done seen", 32'(got), 32'd1);
        f_at = fail; g_at = cur_gen; en_at = en_cnt;
        chk(r7c_at_en == {i7c[31:4], 4'h1}, "R1", "0x7C at ltssm enable",
            r7c_at_en, {i7c[31:4], 4'h1});
        chk(ltssm_en == 1'b1, "R2", "ltssm_en held", 32'(ltssm_en), 32'd1);
        chk(f_at == exp_fail, exp_fail ? "R7" : "R6", "fail flag",
            32'(f_at), 32'(exp_fail));
        if (!exp_fail) begin
            chk(g_at == g, "R6", "cur_gen", 32'(g_at), 32'(g));
            chk(r7c == {i7c[31:4], 4'h2}, "R4", "0x7C after raise",
                r7c, {i7c[31:4], 4'h2});
            chk(sc_wdata == (i80c | 32'h0002_0000), "R4", "0x80C request write",
                sc_wdata, i80c | 32'h0002_0000);
            chk(n7c_rd == 2, "R9", "0x7C read count", 32'(n7c_rd), 32'd2);
        end else begin
            chk(g_at == 4'd0, "R7", "cur_gen on fail", 32'(g_at), 32'd0);
        end
        if (exp_polls >= 0)
            chk(sp_polls == exp_polls, "R5", "speed-bit polls",
                32'(sp_polls), 32'(exp_polls));
        if (chk_win)
            chk(en_at >= WIN - 2 && en_at <= WIN + 2, "R3", "link wait length",
                32'(en_at), 32'(WIN));
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", 32'(done), 32'd0);
        repeat (15) @(negedge clk);
        chk(fail == f_at && cur_gen == g_at, "R7", "results held",
            {fail, 27'd0, cur_gen}, {f_at, 27'd0, g_at});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] p7c [3];
        logic [31:0] p80c [3];
        p7c[0] = 32'h0047_3C1F; p7c[1] = 32'hFFFF_FFF0; p7c[2] = 32'h0000_0003;
        p80c[0] = 32'h0001_2F45; p80c[1] = 32'hFFFD_FFFF; p80c[2] = 32'h0000_0000;
        cfg_7c = '0; cfg_80c = '0; cfg_80 = '0;

        repeat (4) @(negedge clk);
        chk(ltssm_en == 0 && done == 0 && fail == 0 && cur_gen == 0, "R2",
            "reset outputs", {ltssm_en, done, fail, 25'd0, cur_gen}, 32'd0);
        chk(reg_req == 1'b0, "R8", "no access in reset", 32'(reg_req), 32'd0);
        rst = 0;
        repeat (5) @(negedge clk);
        chk(reg_req == 1'b0 && ltssm_en == 1'b0, "R8", "idle quiet",
            {reg_req, ltssm_en}, 32'd0);

        // sweep of generations and register patterns
        for (int g = 1; g <= 3; g++) begin
            for (int p = 0; p < 3; p++) begin
                run_case(p7c[p], p80c[p], 4'(g), g * 7 + p, 3 + 11 * p,
                         0, 0, 0, 0, g * 7 + p + 1, 0);
            end
        end
        // speed-change bit boundaries (R5)
        run_case(p7c[0], p80c[0], 4'd2, 199, 2, 0, 0, 0, 0, 200, 0);
        run_case(p7c[1], p80c[1], 4'd2, 200, 2, 0, 0, 0, 1, 200, 0);
        run_case(p7c[2], p80c[2], 4'd1, 1, 0, 0, 0, 0, 0, 2, 0);
        // link never up, and up but stuck training (R3)
        run_case(p7c[0], p80c[0], 4'd2, 3, -1, 0, 0, 0, 1, 0, 1);
        run_case(p7c[1], p80c[1], 4'd2, 3, 5, 1, 0, 0, 1, 0, 1);
        // link appearing just before and just after the last check (R3)
        run_case(p7c[2], p80c[0], 4'd3, 2, WIN - 8, 0, 0, 0, 0, 3, 0);
        run_case(p7c[0], p80c[2], 4'd3, 2, WIN + 3, 0, 0, 0, 1, 0, 0);
        // link lost after the speed change request
        run_case(p7c[1], p80c[0], 4'd2, 3, 0, 0, 1, 0, 1, 4, 0);
        // start pulses during a run are ignored (R9)
        run_case(p7c[0], p80c[1], 4'd3, 120, 40, 0, 0, 1, 0, 121, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule